// File: doc/BRIEF.md
# I2C Controller Interrupt Aggregator

This block gathers the condition reports of an I2C controller into sticky flag bits and drives one interrupt request to the system interrupt controller. The master engine, the slave engine and the FIFOs produce one-cycle event pulses. The block also watches the transmit and receive FIFO fill levels and compares them against a programmable threshold. Each flag has an enable bit. A flag records its event even when its enable is clear, and only enabled flags can assert the interrupt request.

Firmware reaches the block through a small register port with combinational read data and single-cycle writes. It reads the two flag words to find out why the interrupt was raised. It clears flags by writing ones, and it programs the two enable words and the threshold.

Top module: `i2c_irq_agg`

## Requirements
- R1: After reset, both flag words and both enable words read 0, the threshold reads 4 and `irq_o` is 0.
- R2: A high cycle on `evt0_i[b]` sets bit b of flag word 0 (address 0) at that clock edge. The bit then stays set until software clears it. The bit map is: 0 transfer done, 1 address NACK, 2 data NACK, 3 arbitration lost, 4 timeout, 5 TX lockout during flush, 6 misplaced START/STOP, 7 NACK sent because a FIFO was not ready, 8 address ACK/NACK seen, 9 own address matched, 10 and 11 spare event inputs.
- R3: A high cycle on `evt1_i[0]` (TX underflow) or on `evt1_i[1]` (RX overflow) sets the matching bit 0 or 1 of flag word 1 (address 1), and that bit is sticky.
- R4: A write to address 0 or 1 clears each flag bit whose data bit is 1. Flag bits whose data bit is 0 keep their value.
- R5: When a hardware set and a software clear hit the same flag bit in the same cycle, the bit ends up set.
- R6: Flags latch whether or not their enable bit is set. Enable words are read/write at address 2 (flag word 0) and address 3 (flag word 1).
- R7: `irq_o` is registered. It is 1 in the cycle after any bit of (flag0 AND en0) or of (flag1 AND en1) is 1, and 0 otherwise.
- R8: Clearing an enable bit drops `irq_o` one cycle later and leaves its flag set.
- R9: Flag word 1 bit 2 is set while `tx_lvl_i` is 0 (TX empty). Bit 3 is set while `rx_lvl_i` is nonzero (RX not empty).
- R10: Flag word 1 bit 4 is set while `tx_lvl_i` is at or below the threshold. Bit 5 is set while `rx_lvl_i` is at or above it. The threshold is a 4-bit field at address 4.
- R11: Bits above each register's width read 0, unused addresses read 0, and the threshold keeps only `wdata_i[3:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt0_i | input | 12 | Event pulses for flag word 0 |
| evt1_i | input | 2 | TX underflow / RX overflow pulses |
| tx_lvl_i | input | 5 | TX FIFO fill level |
| rx_lvl_i | input | 5 | RX FIFO fill level |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions assume that event inputs are zero or stable while reset is held. They also assume that a flag only falls after a write to its own address. The stimulus changes inputs one nanosecond after a rising edge and holds each pulse for exactly one cycle. Before it clears level-driven flags, it returns the FIFO levels to values that satisfy none of the level conditions, so the set-wins rule cannot keep those flags alive unexpectedly.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int unsigned DW     = 16;
  localparam int unsigned AW     = 3;
  localparam int unsigned FL0_W  = 12;
  localparam int unsigned PLS1_W = 2;
  localparam int unsigned LVC_W  = 4;
  localparam int unsigned FL1_W  = PLS1_W + LVC_W;
  localparam int unsigned LVL_W  = 5;
  localparam int unsigned THR_W  = 4;
  localparam logic [THR_W-1:0] THR_RST = 4'd4;

  typedef enum logic [AW-1:0] {
    A_FLAG0 = 3'd0,
    A_FLAG1 = 3'd1,
    A_EN0   = 3'd2,
    A_EN1   = 3'd3,
    A_THR   = 3'd4
  } reg_addr_e;

  // level-condition bit order inside flag word 1, above the pulse bits
  localparam int unsigned LV_TX_EMPTY = 0;
  localparam int unsigned LV_RX_NE    = 1;
  localparam int unsigned LV_TX_THR   = 2;
  localparam int unsigned LV_RX_THR   = 3;
endpackage

// File: rtl/i2c_irq_flags.sv
module i2c_irq_flags #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_o[b] <= 1'b0;
      else         flag_o[b] <= set_i[b] | (flag_o[b] & ~clr_i[b]);
    end
  end
endmodule

// File: rtl/i2c_irq_lvl.sv
module i2c_irq_lvl
  import i2c_irq_pkg::*;
#(
  parameter int unsigned LW = LVL_W,
  parameter int unsigned TW = THR_W
) (
  input  logic [LW-1:0]    tx_lvl_i,
  input  logic [LW-1:0]    rx_lvl_i,
  input  logic [TW-1:0]    thr_i,
  output logic [LVC_W-1:0] cond_o
);
  logic [LW-1:0] thr_ext;
  assign thr_ext = LW'(thr_i);

  always_comb begin
    cond_o              = '0;
    cond_o[LV_TX_EMPTY] = (tx_lvl_i == '0);
    cond_o[LV_RX_NE]    = (rx_lvl_i != '0);
    cond_o[LV_TX_THR]   = (tx_lvl_i <= thr_ext);
    cond_o[LV_RX_THR]   = (rx_lvl_i >= thr_ext);
  end
endmodule

// File: rtl/i2c_irq_agg.sv
module i2c_irq_agg
  import i2c_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FL0_W-1:0]  evt0_i,
  input  logic [PLS1_W-1:0] evt1_i,
  input  logic [LVL_W-1:0]  tx_lvl_i,
  input  logic [LVL_W-1:0]  rx_lvl_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              irq_o
);
  logic              wr;
  logic [FL0_W-1:0]  flag0_q, en0_q, clr0;
  logic [FL1_W-1:0]  flag1_q, en1_q, clr1, set1;
  logic [LVC_W-1:0]  lv_cond;
  logic [THR_W-1:0]  thr_q;
  logic              unused_wdata;

  assign wr           = req_i & we_i;
  assign unused_wdata = ^wdata_i[DW-1:FL0_W];

  assign clr0 = (wr && addr_i == A_FLAG0) ? wdata_i[FL0_W-1:0] : '0;
  assign clr1 = (wr && addr_i == A_FLAG1) ? wdata_i[FL1_W-1:0] : '0;

  i2c_irq_lvl u_lvl (
    .tx_lvl_i (tx_lvl_i),
    .rx_lvl_i (rx_lvl_i),
    .thr_i    (thr_q),
    .cond_o   (lv_cond)
  );

  assign set1 = {lv_cond, evt1_i};

  i2c_irq_flags #(.W(FL0_W)) u_flags0 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (evt0_i),
    .clr_i  (clr0),
    .flag_o (flag0_q)
  );

  i2c_irq_flags #(.W(FL1_W)) u_flags1 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set1),
    .clr_i  (clr1),
    .flag_o (flag1_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en0_q <= '0;
      en1_q <= '0;
      thr_q <= THR_RST;
    end else if (wr) begin
      if (addr_i == A_EN0) en0_q <= wdata_i[FL0_W-1:0];
      if (addr_i == A_EN1) en1_q <= wdata_i[FL1_W-1:0];
      if (addr_i == A_THR) thr_q <= wdata_i[THR_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |{flag0_q & en0_q, flag1_q & en1_q};
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_FLAG0: rdata_o = DW'(flag0_q);
      A_FLAG1: rdata_o = DW'(flag1_q);
      A_EN0:   rdata_o = DW'(en0_q);
      A_EN1:   rdata_o = DW'(en1_q);
      A_THR:   rdata_o = DW'(thr_q);
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/i2c_irq_chk.sv
module i2c_irq_chk
  import i2c_irq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [FL0_W-1:0]  evt0_i,
  input logic [PLS1_W-1:0] evt1_i,
  input logic [LVL_W-1:0]  tx_lvl_i,
  input logic              req_i,
  input logic              we_i,
  input logic [AW-1:0]     addr_i,
  input logic [FL0_W-1:0]  flag0,
  input logic [FL1_W-1:0]  flag1,
  input logic [FL0_W-1:0]  en0,
  input logic [FL1_W-1:0]  en1,
  input logic [THR_W-1:0]  thr,
  input logic              irq_o
);
  logic wr0, wr1, any_act;
  assign wr0     = req_i && we_i && addr_i == A_FLAG0;
  assign wr1     = req_i && we_i && addr_i == A_FLAG1;
  assign any_act = |{flag0 & en0, flag1 & en1};

  // set beats clear as well (R5)
  p_evt0_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt0_i) |=> ((flag0 & $past(evt0_i)) == $past(evt0_i)));

  p_evt1_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt1_i) |=> ((flag1[PLS1_W-1:0] & $past(evt1_i)) == $past(evt1_i)));

  p_sticky0_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr0 |=> ((flag0 & $past(flag0)) == $past(flag0)));

  p_sticky1_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr1 |=> ((flag1 & $past(flag1)) == $past(flag1)));

  p_irq_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_act |=> irq_o);

  p_irq_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_act |=> !irq_o);

  p_tx_thr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_lvl_i <= LVL_W'(thr)) |=> flag1[PLS1_W + LV_TX_THR]);
endmodule

bind i2c_irq_agg i2c_irq_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .evt0_i   (evt0_i),
  .evt1_i   (evt1_i),
  .tx_lvl_i (tx_lvl_i),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .flag0    (flag0_q),
  .flag1    (flag1_q),
  .en0      (en0_q),
  .en1      (en1_q),
  .thr      (thr_q),
  .irq_o    (irq_o)
);

// File: tb/test_i2c_irq_agg.sv
module test_i2c_irq_agg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] evt0 = '0;
  logic [1:0]  evt1 = '0;
  logic [4:0]  tx_lvl = 5'd8;
  logic [4:0]  rx_lvl = 5'd0;
  logic        req = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 1'b0;

  typedef struct { logic [15:0] exp; string tag; } item_t;
  item_t sb[$];

  always #5 clk = ~clk;

  i2c_irq_agg i_i2c_irq_agg (
    .clk_i(clk), .rst_ni(rst_n), .evt0_i(evt0), .evt1_i(evt1),
    .tx_lvl_i(tx_lvl), .rx_lvl_i(rx_lvl), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // monitor: compares read data against scoreboard on every read strobe
  always @(negedge clk) begin
    if (req && !we) begin
      item_t it;
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL scoreboard empty: actual %h expected none", rdata);
      end else begin
        it = sb.pop_front();
        if (rdata !== it.exp) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", it.tag, rdata, it.exp);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic rd(input logic [2:0] a, input logic [15:0] exp, input string tag);
    item_t it;
    it.exp = exp; it.tag = tag;
    sb.push_back(it);
    @(posedge clk); #1;
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); #1;
    req = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic pulse0(input logic [11:0] v);
    @(posedge clk); #1; evt0 = v;
    @(posedge clk); #1; evt0 = '0;
  endtask

  task automatic pulse1(input logic [1:0] v);
    @(posedge clk); #1; evt1 = v;
    @(posedge clk); #1; evt1 = '0;
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    @(posedge clk); @(posedge clk); @(negedge clk);
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, irq, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    rd(3'd0, 16'h0000, "R1 flag0");
    rd(3'd1, 16'h0000, "R1 flag1");
    rd(3'd2, 16'h0000, "R1 en0");
    rd(3'd3, 16'h0000, "R1 en1");
    rd(3'd4, 16'h0004, "R1 thr");
    chk_irq(1'b0, "R1 irq");
    rd(3'd5, 16'h0000, "R11 unused addr");
    // R2 / R6: flags latch with enables off
    pulse0(12'h008);
    rd(3'd0, 16'h0008, "R2 single event");
    chk_irq(1'b0, "R6 disabled flag no irq");
    pulse0(12'h801);
    rd(3'd0, 16'h0809, "R2 multi event sticky");
    // R4 write-one-to-clear
    wr(3'd0, 16'h0001);
    rd(3'd0, 16'h0808, "R4 clear one bit");
    wr(3'd0, 16'h0000);
    rd(3'd0, 16'h0808, "R4 zero write no effect");
    // R7 / R8
    wr(3'd2, 16'h0800);
    rd(3'd2, 16'h0800, "R6 en0 readback");
    chk_irq(1'b1, "R7 irq from word0");
    wr(3'd2, 16'h0000);
    chk_irq(1'b0, "R8 irq drops on disable");
    rd(3'd0, 16'h0808, "R8 flag kept after disable");
    // R3 and irq through word 1
    pulse1(2'b10);
    rd(3'd1, 16'h0002, "R3 rx overflow");
    pulse1(2'b01);
    rd(3'd1, 16'h0003, "R3 tx underflow");
    wr(3'd3, 16'h0002);
    chk_irq(1'b1, "R7 irq from word1");
    wr(3'd3, 16'h0000);
    chk_irq(1'b0, "R8 irq word1 disable");
    // R5 set wins over same-cycle clear
    @(posedge clk); #1;
    req = 1'b1; we = 1'b1; addr = 3'd0; wdata = 16'h0008; evt0 = 12'h008;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0; evt0 = '0;
    rd(3'd0, 16'h0808, "R5 set wins");
    wr(3'd0, 16'hFFFF);
    rd(3'd0, 16'h0000, "R4 clear all word0");
    wr(3'd1, 16'h003F);
    rd(3'd1, 16'h0000, "R4 clear all word1");
    // R9 / R10 level conditions
    @(posedge clk); #1 tx_lvl = 5'd0;
    rd(3'd1, 16'h0014, "R9 tx empty and R10 tx thr");
    @(posedge clk); #1 tx_lvl = 5'd8;
    wr(3'd1, 16'h003F);
    rd(3'd1, 16'h0000, "R9 clear after level restore");
    @(posedge clk); #1 rx_lvl = 5'd3;
    rd(3'd1, 16'h0008, "R9 rx not empty below thr");
    @(posedge clk); #1 rx_lvl = 5'd4;
    rd(3'd1, 16'h0028, "R10 rx at thr");
    @(posedge clk); #1 rx_lvl = 5'd0;
    wr(3'd1, 16'h003F);
    rd(3'd1, 16'h0000, "R10 clear");
    wr(3'd4, 16'h0009);
    rd(3'd4, 16'h0009, "R10 thr readback");
    rd(3'd1, 16'h0010, "R10 tx at or below new thr");
    wr(3'd4, 16'hFFF7);
    rd(3'd4, 16'h0007, "R11 thr width mask");
    wr(3'd2, 16'hFFFF);
    rd(3'd2, 16'h0FFF, "R11 en0 width mask");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule